// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two W-bit operands over W clock cycles and returns a 2W-bit product split across a high register and a low register. A one-cycle `start` pulse, given while the unit is idle, captures both operands and the `is_signed` select. Each following cycle looks at the least significant bit of a double-width partial-product register. When that bit is one, the multiplicand is added into the upper half. In the same clock edge the register moves one place to the right. The add and the shift both happen in the wiring of the register's next-value path, so one iteration takes one cycle.

The multiplier operand starts in the low half of the partial-product register. Each iteration uses up one of its bits, and the product fills the register from the top. In signed mode the operands are first reduced to their magnitudes, and the unsigned core multiplies those. If exactly one operand was negative, the final 2W-bit result is negated before it is written to `hi`/`lo`. `done` marks the single cycle in which a new result first appears. `hi`/`lo` keep that result until the next run finishes.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done`, `hi` and `lo` are all zero.
- R2: A `start` pulse sampled while `busy` is low captures `opnd_a`, `opnd_b` and `is_signed`, and `busy` is high in the following cycle.
- R3: `done` goes high for exactly one cycle, W clock cycles after the cycle in which `start` was accepted. `busy` falls in that same cycle.
- R4: With `is_signed` = 0 both operands are read as unsigned, and {`hi`,`lo`} equals their full 2W-bit product: `hi` holds bits 2W-1..W and `lo` holds bits W-1..0.
- R5: With `is_signed` = 1 both operands are read as two's complement, and {`hi`,`lo`} is the 2W-bit two's complement product.
- R6: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands, its timing and its result.
- R7: `hi` and `lo` change only in a cycle where `done` is high, and otherwise hold the last result.
- R8: In signed mode the most negative operand value (only bit W-1 set) is handled correctly, for example min × min = 2^(2W-2) and min × (−1) = 2^(W-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| opnd_a | input | W | Multiplicand |
| opnd_b | input | W | Multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when a new product is in `hi`/`lo` |
| hi | output | W | Upper half of the product |
| lo | output | W | Lower half of the product |

## Verification
The bench builds the block with W = 6. At that width every operand pair in both signed and unsigned modes takes about 65 thousand cycles in total. This covers every carry pattern out of the 7-bit adder, every sign combination, and the most negative value whose magnitude fills the whole word. Directed runs at the same width inject a second `start` in the middle of an iteration and watch `done` and the held result around completion. The cycle-count checks do not depend on the width chosen.

// File: rtl/mul_pkg.sv
`timescale 1ns/1ps
package mul_pkg;
  // Sequencer states of the iterative multiplier.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_prep.sv
`timescale 1ns/1ps
// Sign-magnitude front end: turns operands into unsigned magnitudes
// and reports whether the product must be negated at the end.
module mul_prep #(
  parameter int W = 32
) (
  input  logic         is_signed,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_res
);
  // Magnitude of a W-bit word; the most negative value maps to 2^(W-1),
  // which still fits in W unsigned bits.
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x,
                                             input logic sgn);
    if (sgn && x[W-1]) return (~x) + W'(1);
    return x;
  endfunction

  always_comb begin
    mag_a   = magnitude(opnd_a, is_signed);
    mag_b   = magnitude(opnd_b, is_signed);
    neg_res = is_signed & (opnd_a[W-1] ^ opnd_b[W-1]);
  end
endmodule

// File: rtl/mul_ctrl.sv
`timescale 1ns/1ps
// Iteration sequencer: accepts start when idle, counts W steps.
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 32,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          load,
  output logic          step,
  output logic          last,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] iter_cnt
);
  mul_state_e state_q;

  always_comb begin
    busy = (state_q == ST_RUN);
    load = start && (state_q == ST_IDLE);
    step = busy;
    last = step && (iter_cnt == CW'(W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      iter_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        state_q  <= ST_RUN;
        iter_cnt <= '0;
      end else if (step) begin
        iter_cnt <= iter_cnt + CW'(1);
        if (last) state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/mul_core.sv
`timescale 1ns/1ps
// Unsigned shift-add datapath: one multiplier bit per cycle, with the
// right shift folded into the partial-product register's load path.
module mul_core #(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [W-1:0]  mag_a,
  input  logic [W-1:0]  mag_b,
  output logic [PW-1:0] pp_next,
  output logic          add_en
);
  logic [W-1:0]  mcand_q;
  logic [PW-1:0] pp_q;

  // One iteration: a conditional add into the upper half, with a W+1-bit
  // sum whose carry becomes the new MSB, then a shift right by one.
  function automatic logic [PW-1:0] add_shift(input logic [PW-1:0] pp,
                                              input logic [W-1:0] mc);
    logic [W:0] sum;
    sum = {1'b0, pp[PW-1:W]};
    if (pp[0]) sum = sum + {1'b0, mc};
    return {sum, pp[W-1:1]};
  endfunction

  always_comb begin
    add_en  = pp_q[0];
    pp_next = add_shift(pp_q, mcand_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      pp_q    <= '0;
    end else if (load) begin
      mcand_q <= mag_a;
      pp_q    <= {{W{1'b0}}, mag_b};
    end else if (step) begin
      pp_q <= pp_next;
    end
  end
endmodule

// File: rtl/mul_result.sv
`timescale 1ns/1ps
// Result stage: remembers the sign fix-up and writes the hi/lo pair.
module mul_result #(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          neg_in,
  input  logic          capture,
  input  logic [PW-1:0] prod_in,
  output logic [W-1:0]  hi,
  output logic [W-1:0]  lo
);
  logic neg_q;

  function automatic logic [PW-1:0] negate(input logic [PW-1:0] x);
    return (~x) + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
      hi    <= '0;
      lo    <= '0;
    end else begin
      if (load) neg_q <= neg_in;
      if (capture) {hi, lo} <= neg_q ? negate(prod_in) : prod_in;
    end
  end
endmodule

// File: rtl/shiftadd_mul.sv
`timescale 1ns/1ps
// Multi-cycle W x W multiplier with hi/lo product registers.
module shiftadd_mul #(
  parameter int W = 32,
  localparam int PW = 2 * W,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  // Named internal events, visible to the bound checker.
  logic          load;
  logic          step;
  logic          last_iter;
  logic [CW-1:0] iter_cnt;
  logic [W-1:0]  mag_a;
  logic [W-1:0]  mag_b;
  logic          neg_res;
  logic [PW-1:0] pp_next;
  logic          add_en;

  mul_prep #(.W(W)) u_prep (
    .is_signed (is_signed),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .neg_res   (neg_res)
  );

  mul_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load     (load),
    .step     (step),
    .last     (last_iter),
    .busy     (busy),
    .done     (done),
    .iter_cnt (iter_cnt)
  );

  mul_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .mag_a   (mag_a),
    .mag_b   (mag_b),
    .pp_next (pp_next),
    .add_en  (add_en)
  );

  mul_result #(.W(W)) u_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .neg_in  (neg_res),
    .capture (last_iter),
    .prod_in (pp_next),
    .hi      (hi),
    .lo      (lo)
  );
endmodule

// File: rtl/shiftadd_mul_chk.sv
`timescale 1ns/1ps
// Protocol checker for shiftadd_mul, attached by bind.
module shiftadd_mul_chk #(
  parameter int W = 32,
  localparam int CW = (W > 1) ? $clog2(W) : 1,
  localparam int DW = $clog2(W + 2) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          last_iter,
  input logic [CW-1:0] iter_cnt,
  input logic [W-1:0]  hi,
  input logic [W-1:0]  lo
);
  // Busy-cycle counter measuring the run length.
  logic [DW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (start && !busy) run_len <= '0;
    else if (busy) run_len <= run_len + DW'(1);
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R3
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == DW'(W)));

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_iter) |=> (busy && iter_cnt == $past(iter_cnt) + CW'(1)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi) && $stable(lo)));
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.W(W)) u_shiftadd_mul_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .last_iter (last_iter),
  .iter_cnt  (iter_cnt),
  .hi        (hi),
  .lo        (lo)
);

// File: tb/shiftadd_mul_bench.sv
`timescale 1ns/1ps
module shiftadd_mul_bench;
  localparam int TW = 6;
  localparam int TP = 2 * TW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          is_signed = 1'b0;
  logic [TW-1:0] opnd_a = '0;
  logic [TW-1:0] opnd_b = '0;
  logic          busy;
  logic          done;
  logic [TW-1:0] hi;
  logic [TW-1:0] lo;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  shiftadd_mul #(.W(TW)) u_shiftadd_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .done(done),
    .hi(hi), .lo(lo)
  );

  // Reference product by sign/zero extension to 2W and native multiply.
  function automatic logic [TP-1:0] ref_prod(input logic [TW-1:0] a,
                                             input logic [TW-1:0] b,
                                             input logic s);
    logic signed [TP-1:0] sa, sb;
    if (s) begin
      sa = {{TW{a[TW-1]}}, a};
      sb = {{TW{b[TW-1]}}, b};
      return TP'(sa * sb);
    end
    return {{TW{1'b0}}, a} * {{TW{1'b0}}, b};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One multiplication. If inj is set, a second start with other
  // operands is pulsed two cycles into the run.
  task automatic run_op(input logic [TW-1:0] a, input logic [TW-1:0] b,
                        input logic s, input bit inj, input bit hold_chk);
    int got;
    logic [TP-1:0] exp;
    exp = ref_prod(a, b, s);
    @(negedge clk);
    opnd_a = a; opnd_b = b; is_signed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    got = -1;
    for (int i = 1; i <= TW + 1; i++) begin
      if (inj && i == 2) begin
        opnd_a = ~a; opnd_b = b + TW'(1); is_signed = ~s; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (done && got < 0) begin
        got = i;
        check(busy == 1'b0, "R3 busy low with done", longint'(busy), 0);
        check({hi, lo} == exp, s ? "R5 signed product" : "R4 unsigned product",
              longint'({hi, lo}), longint'(exp));
        if (inj)
          check({hi, lo} == exp, "R6 start while busy ignored",
                longint'({hi, lo}), longint'(exp));
        break;
      end
    end
    check(got == TW, "R3 done latency", longint'(got), longint'(TW));
    if (hold_chk) begin
      opnd_a = ~a; opnd_b = ~b;
      @(negedge clk);
      check(done == 1'b0, "R3 done single cycle", longint'(done), 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check({hi, lo} == exp, "R7 result held",
              longint'({hi, lo}), longint'(exp));
      end
    end
  endtask

  initial begin
    logic [TW-1:0] mn;
    mn = {1'b1, {(TW-1){1'b0}}};
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(!busy && !done && hi == '0 && lo == '0, "R1 reset state",
          longint'({busy, done, hi, lo}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && hi == '0 && lo == '0, "R1 after reset",
          longint'({busy, done, hi, lo}), 0);

    // Directed: hold and restart injection
    run_op(TW'(5), TW'(7), 1'b0, 1'b0, 1'b1);
    run_op(TW'(3), ~TW'(1), 1'b1, 1'b1, 1'b1);
    run_op('1, '1, 1'b0, 1'b1, 1'b1);

    // R8: most negative operand in signed mode
    run_op(mn, mn, 1'b1, 1'b0, 1'b0);
    check({hi, lo} == (TP'(1) << (TP - 2)), "R8 min*min",
          longint'({hi, lo}), longint'(TP'(1) << (TP - 2)));
    run_op(mn, '1, 1'b1, 1'b0, 1'b0);
    check({hi, lo} == (TP'(1) << (TW - 1)), "R8 min*-1",
          longint'({hi, lo}), longint'(TP'(1) << (TW - 1)));
    run_op(mn, TW'(1), 1'b1, 1'b0, 1'b1);

    // Exhaustive sweep: R4 unsigned, R5 signed
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << TW); a++)
        for (int b = 0; b < (1 << TW); b++)
          run_op(TW'(a), TW'(b), s[0], 1'b0, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule